// File: doc/BRIEF.md
# Fuse-Configurable Programmable Array Logic Engine

This block emulates a small programmable array logic device in ordinary synthesizable logic. Four primary inputs and four outputs are joined by an AND plane whose connections come from configuration bits, and by an OR plane that is fixed. Each output ORs together exactly three product terms that belong to it alone. Any product term can take the true or the complemented form of any primary input. It can also take the true or complemented form of any output with a lower number, so multi-level functions can be built without combinational loops. Each output has a polarity bit that can invert it, which allows product-of-sums forms.

The configuration is held in two registers. A shift register is filled serially, most significant bit first, while the shift enable is high. A single-cycle load strobe then copies it into the active map in one step, so the logic never evaluates a partly written map. The data path from `data_in` to `func_out` is purely combinational.

Map layout: there are 12 product terms, numbered 0 to 11, and term t belongs to output t/3. There are 8 literal sources: s = 0..3 are data_in[0..3], and s = 4..7 are func_out[0..3]. Term t uses bits t*16 .. t*16+15. The true-form fuse of source s is at bit t*16+2s and the complement fuse is at bit t*16+2s+1. The polarity bit of output g is at bit 192+g. The map is 196 bits wide, and the bit shifted in first ends up at bit 195.

Top module: `pal_engine`

## Requirements
- R1: While reset is asserted, and after it is released, both the shift register and the active map are all zero. func_out is therefore 0000 for every data_in until a map is loaded.
- R2: On each clock edge with cfg_shift high, the shift register moves one place toward its MSB and takes cfg_din into bit 0. With cfg_shift low it holds its value.
- R3: The active map changes only on an edge where cfg_load is high, and then it takes the shift-register contents. Shifting without a load leaves func_out unchanged.
- R4: With the reference map loaded, func_out[0..3] give F1 = C'+A'B', F2 = A'BC'+AC+AB', F3 = AD+BD+F1 and F4 = AB+CD+F1'. Here A..D are data_in[0..3], and this holds for all 16 input values.
- R5: A product term with no selected fuse evaluates to 0, so an output whose terms are all empty equals its polarity bit.
- R6: A product term that selects both the true and the complemented form of the same source evaluates to 0.
- R7: A source with both fuses clear is a don't-care in its term.
- R8: Fuses that select an output of the same or a higher number than the term's own output have no effect.
- R9: When an output's polarity bit is 1, that output is the complement of the OR of its terms.
- R10: Feedback literals use the output after polarity is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shift | input | 1 | Shift enable for the configuration register |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_load | input | 1 | Copies the shift register into the active map |
| data_in | input | 4 | Primary inputs A..D at bits 0..3 |
| func_out | output | 4 | Outputs F1..F4 at bits 0..3 |

## Verification
The hardest cases to reach from the ports are fuses that point at an output's own or a later output, and a map that changes while a partial shift is in progress. The bench reaches them by writing a full 196-bit map with a term that selects the same output and a later output alongside a primary input. That output must then follow the primary input alone. The bench also shifts a partial pattern over a loaded reference map and confirms all outputs are unchanged. Reloading the reference map with its first output inverted shows the inversion spreading through feedback into the third and fourth outputs.

// File: rtl/pal_engine.sv
module pal_engine #(
  parameter int N_IN = 4,
  parameter int N_OUT = 4,
  parameter int TPG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_shift,
  input  logic             cfg_din,
  input  logic             cfg_load,
  input  logic [N_IN-1:0]  data_in,
  output logic [N_OUT-1:0] func_out
);
  localparam int SRC = N_IN + N_OUT;
  localparam int TW  = 2 * SRC;
  localparam int NT  = N_OUT * TPG;
  localparam int POL = NT * TW;
  localparam int MW  = POL + N_OUT;

  logic [MW-1:0]    shreg, fmap;
  logic [NT-1:0]    term_v;
  logic [N_OUT-1:0] fo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      fmap  <= '0;
    end else begin
      if (cfg_shift) shreg <= {shreg[MW-2:0], cfg_din};
      if (cfg_load)  fmap  <= shreg;
    end
  end

  always_comb begin
    logic any, prod, lit, tb, cb, orv;
    fo = '0;
    term_v = '0;
    for (int g = 0; g < N_OUT; g++) begin
      orv = 1'b0;
      for (int k = 0; k < TPG; k++) begin
        any = 1'b0;
        prod = 1'b1;
        for (int s = 0; s < SRC; s++) begin
          tb = fmap[(g*TPG+k)*TW + 2*s];
          cb = fmap[(g*TPG+k)*TW + 2*s + 1];
          lit = 1'b0;
          if (s < N_IN) lit = data_in[s];
          else if (s - N_IN < g) lit = fo[s-N_IN];
          if (s < N_IN || s - N_IN < g) begin
            any = any | tb | cb;
            if (tb && !lit) prod = 1'b0;
            if (cb && lit) prod = 1'b0;
          end
        end
        term_v[g*TPG+k] = any & prod;
        orv = orv | (any & prod);
      end
      fo[g] = orv ^ fmap[POL+g];
    end
  end

  assign func_out = fo;

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift |=> shreg[0] == $past(cfg_din));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift |=> $stable(shreg));
  a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> fmap == $past(shreg));
  a_r3_map_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_load) |-> $stable(fmap));
  a_r5_empty_group: assert property (@(posedge clk) disable iff (!rst_n)
    (term_v[TPG-1:0] == '0) |-> func_out[0] == fmap[POL]);
endmodule

// File: tb/test_pal_engine.sv
module test_pal_engine;
  localparam int MW = 196;
  logic clk = 0, rst_n = 0, cfg_shift = 0, cfg_din = 0, cfg_load = 0;
  logic [3:0] data_in = 0;
  logic [3:0] func_out;
  logic [MW-1:0] m;
  int total = 0, fails = 0;
  bit done = 0;

  pal_engine i_pal_engine (.clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift),
    .cfg_din(cfg_din), .cfg_load(cfg_load), .data_in(data_in), .func_out(func_out));

  always #2 clk = ~clk;

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: in=%b actual=%b expected=%b", req, data_in, act, exp);
    end
  endtask

  task automatic fuse(int t, int s, bit c);
    m[t*16 + 2*s + (c ? 1 : 0)] = 1'b1;
  endtask

  task automatic shift_bits(logic [MW-1:0] v, int n);
    for (int i = MW-1; i >= MW-n; i--) begin
      @(negedge clk); cfg_shift = 1; cfg_din = v[i];
    end
    @(negedge clk); cfg_shift = 0;
  endtask

  task automatic load_map(logic [MW-1:0] v);
    shift_bits(v, MW);
    cfg_load = 1;
    @(negedge clk); cfg_load = 0;
  endtask

  function automatic logic [3:0] ref_f(logic [3:0] x, bit p1);
    logic a, b, c, d, f1, f2, f3, f4;
    {d, c, b, a} = x;
    f1 = (~c | (~a & ~b)) ^ p1;
    f2 = (~a & b & ~c) | (a & c) | (a & ~b);
    f3 = (a & d) | (b & d) | f1;
    f4 = (a & b) | (c & d) | ~f1;
    return {f4, f3, f2, f1};
  endfunction

  task automatic build_ref(bit p1);
    m = '0;
    fuse(0, 2, 1);
    fuse(1, 0, 1); fuse(1, 1, 1);
    fuse(3, 0, 1); fuse(3, 1, 0); fuse(3, 2, 1);
    fuse(4, 0, 0); fuse(4, 2, 0);
    fuse(5, 0, 0); fuse(5, 1, 1);
    fuse(6, 0, 0); fuse(6, 3, 0);
    fuse(7, 1, 0); fuse(7, 3, 0);
    fuse(8, 4, 0);
    fuse(9, 0, 0); fuse(9, 1, 0);
    fuse(10, 2, 0); fuse(10, 3, 0);
    fuse(11, 4, 1);
    m[192] = p1;
  endtask

  task automatic sweep(string req, bit p1);
    for (int x = 0; x < 16; x++) begin
      data_in = 4'(x); #1;
      chk(req, func_out, ref_f(4'(x), p1));
    end
  endtask

  task automatic t_reset;
    for (int x = 0; x < 16; x += 5) begin
      data_in = 4'(x); #1; chk("R1", func_out, 4'b0000);
    end
  endtask

  task automatic t_shift_no_load;
    build_ref(0);
    shift_bits(m, MW);
    data_in = 4'b0000; #1; chk("R3 no load", func_out, 4'b0000);
  endtask

  task automatic t_reference;
    cfg_load = 1; @(negedge clk); cfg_load = 0;
    sweep("R4 R7", 0);
  endtask

  task automatic t_partial;
    logic [MW-1:0] z;
    z = '0;
    shift_bits(z, 60);
    sweep("R2 R3 partial", 0);
  endtask

  task automatic t_empty_pol;
    m = '0; m[195:192] = 4'b1111;
    load_map(m);
    data_in = 4'b1010; #1; chk("R5 R9 pol", func_out, 4'b1111);
    m = '0; load_map(m);
    data_in = 4'b0101; #1; chk("R5 empty", func_out, 4'b0000);
  endtask

  task automatic t_contra;
    m = '0; fuse(0, 0, 0); fuse(0, 0, 1); fuse(1, 1, 0);
    load_map(m);
    data_in = 4'b0001; #1; chk("R6", func_out, 4'b0000);
    data_in = 4'b0011; #1; chk("R6 R7", func_out, 4'b0001);
  endtask

  task automatic t_feedback_ignored;
    m = '0; fuse(0, 0, 0); fuse(0, 4, 0); fuse(0, 5, 0);
    fuse(3, 6, 1);
    load_map(m);
    data_in = 4'b0001; #1; chk("R8", func_out, 4'b0001);
    data_in = 4'b0000; #1; chk("R8", func_out, 4'b0000);
  endtask

  task automatic t_polarity_feedback;
    build_ref(1);
    load_map(m);
    sweep("R9 R10", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_shift_no_load();
    t_reference();
    t_partial();
    t_empty_pol();
    t_contra();
    t_feedback_ignored();
    t_polarity_feedback();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule